// File: doc/BRIEF.md
# Pulse-Inhibit Clock Calibrator with Trim Programming

The block divides a 4.194304 MHz (2^22 Hz) reference clock down to a one-cycle strobe once per second. The reference clock is also the block's clock. A prescaler first divides by 16 to give a 262144 Hz enable stream. A second counter then counts 2^18 of those enables to make each second.

The crystal is deliberately tuned a little fast, about +60 ppm. To correct for this, the block drops a programmable number n of stream enables at the start of every second. During those first n enables the second counter holds still, so a second lasts 2^18 + n stream periods.

The value n, and a second 5-bit value for the display-voltage regulator, are set with a small pulse protocol:

- Programming is allowed only while the programming-mode input and the high-voltage-present input are both high.
- In each programming session, the first rising edge on the data input clears the working value to zero.
- Each later rising edge adds one, and 31 wraps back to 0.
- A rising edge on the store input copies the working value into one of two committed registers. The target select input picks which one.
- The committed registers stand in for non-volatile cells and are modelled as flops.

All inputs are assumed synchronous to the clock and already debounced. The block has no data stream. Its outputs are plain strobes and levels with no back-pressure: a tick cannot be held off, and a consumer must take it in the cycle it appears.

Top module: `osc_trim_calibrator`

## Requirements
- R1: After reset, the working value is 0, both committed values hold their reset defaults (0), and the second tick is low.
- R2: The stream enable is high for exactly one cycle in every 2^DIV_LOG2 clock cycles.
- R3: With committed calibration value n, consecutive second ticks are (2^SEC_LOG2 + n) * 2^DIV_LOG2 clock cycles apart. A newly committed n applies from the second that begins after the commit.
- R4: The second tick is one cycle wide and is only ever high in a cycle where the stream enable is high.
- R5: The first data rising edge of a programming session sets the working value to 0.
- R6: Each later data rising edge in the same session raises the working value by exactly 1.
- R7: A data rising edge while the working value is 31 makes it 0.
- R8: A store rising edge copies the working value into the calibration register when the target select is 0, and into the display-voltage register when it is 1. The other committed register is left unchanged.
- R9: Unless programming mode and high voltage are both high, data and store edges change neither the working value nor either committed value.
- R10: Any cycle outside programming re-arms the session, so the next data edge clears again.
- R11: When data and store rise in the same cycle, the store commits the working value held before that data edge, and the data edge still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 2^22 Hz nominal |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_mode | input | 1 | Programming mode requested (select input left open) |
| vpp_hi | input | 1 | Programming voltage present |
| trim_sel | input | 1 | Store target: 0 calibration, 1 display voltage |
| data_pulse | input | 1 | Clear/increment pulse input, acts on rising edge |
| store_pulse | input | 1 | Commit pulse input, acts on rising edge |
| stream_en | output | 1 | One-cycle enable at the intermediate (262144 Hz) rate |
| tick_1hz | output | 1 | One-cycle strobe once per corrected second |
| work_trim | output | 5 | Working trim value |
| cal_trim | output | 5 | Committed calibration value n |
| lcd_trim | output | 5 | Committed display-voltage trim value |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is a data edge and a store edge. The bench raises both inputs on the same clock edge, and also does so at random. It then checks two things: that the committed register holds the pre-increment value, and that the working value has still stepped (R11).

The second pair is a commit and a second boundary. The inhibit count for a second is loaded only at that second's boundary, so the bench commits n while a second is running. It then measures the span between the next two ticks and compares it with the period that n predicts.

// File: rtl/cal_pkg.sv
package cal_pkg;

  // Which committed register a store pulse writes.
  typedef enum logic {
    TGT_CAL = 1'b0,
    TGT_LCD = 1'b1
  } trim_tgt_e;

endpackage

// File: rtl/cal_prescaler.sv
// Divides the reference clock by 2^DIV_LOG2 and emits a one-cycle enable.
module cal_prescaler #(
  parameter int DIV_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic stream_en
);

  logic [DIV_LOG2-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  // The enable fires on the terminal count.
  assign stream_en = &div_q;

endmodule

// File: rtl/cal_second_counter.sv
// Counts stream enables into seconds. The first n enables of each second are
// swallowed by an inhibit down-counter loaded at the second boundary.
module cal_second_counter #(
  parameter int SEC_LOG2 = 18,
  parameter int TRIM_W   = 5,
  parameter int CAL_INIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stream_en,
  input  logic [TRIM_W-1:0] cal_n,
  output logic              tick_1hz
);

  localparam logic [SEC_LOG2-1:0] SEC_MAX = {SEC_LOG2{1'b1}};

  logic [SEC_LOG2-1:0] sec_q;
  logic [TRIM_W-1:0]   inhib_q;
  logic                inhibiting;
  logic                advance;

  assign inhibiting = (inhib_q != '0);
  assign advance    = stream_en && !inhibiting;
  assign tick_1hz   = advance && (sec_q == SEC_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q   <= '0;
      inhib_q <= TRIM_W'(CAL_INIT);
    end else if (stream_en) begin
      if (inhibiting) begin
        inhib_q <= inhib_q - 1'b1;
      end else if (sec_q == SEC_MAX) begin
        // Second boundary: wrap and load the inhibit count for the next second.
        sec_q   <= '0;
        inhib_q <= cal_n;
      end else begin
        sec_q <= sec_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cal_trim_prog.sv
// Pulse protocol for the working trim value and its commit into two
// committed registers.
module cal_trim_prog
  import cal_pkg::*;
#(
  parameter int TRIM_W   = 5,
  parameter int CAL_INIT = 0,
  parameter int LCD_INIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_mode,
  input  logic              vpp_hi,
  input  logic              trim_sel,
  input  logic              data_pulse,
  input  logic              store_pulse,
  output logic [TRIM_W-1:0] work_trim,
  output logic [TRIM_W-1:0] cal_trim,
  output logic [TRIM_W-1:0] lcd_trim
);

  logic      data_q, store_q;
  logic      armed_q;
  logic      prog_ok;
  logic      data_rise, store_rise;
  trim_tgt_e tgt;

  assign prog_ok    = prog_mode && vpp_hi;
  assign data_rise  = data_pulse && !data_q;
  assign store_rise = store_pulse && !store_q;
  assign tgt        = trim_tgt_e'(trim_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= 1'b0;
      store_q <= 1'b0;
    end else begin
      data_q  <= data_pulse;
      store_q <= store_pulse;
    end
  end

  // Working value: clear on the first edge of a session, then step with wrap.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q   <= 1'b1;
      work_trim <= '0;
    end else if (!prog_ok) begin
      armed_q <= 1'b1;
    end else if (data_rise) begin
      if (armed_q) begin
        work_trim <= '0;
        armed_q   <= 1'b0;
      end else begin
        work_trim <= work_trim + 1'b1;
      end
    end
  end

  // Commit samples the pre-edge working value, so a coincident data edge
  // does not leak into the stored value.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_trim <= TRIM_W'(CAL_INIT);
      lcd_trim <= TRIM_W'(LCD_INIT);
    end else if (prog_ok && store_rise) begin
      case (tgt)
        TGT_CAL: cal_trim <= work_trim;
        TGT_LCD: lcd_trim <= work_trim;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/osc_trim_calibrator.sv
module osc_trim_calibrator #(
  parameter int DIV_LOG2 = 4,
  parameter int SEC_LOG2 = 18,
  parameter int TRIM_W   = 5,
  parameter int CAL_INIT = 0,
  parameter int LCD_INIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_mode,
  input  logic              vpp_hi,
  input  logic              trim_sel,
  input  logic              data_pulse,
  input  logic              store_pulse,
  output logic              stream_en,
  output logic              tick_1hz,
  output logic [TRIM_W-1:0] work_trim,
  output logic [TRIM_W-1:0] cal_trim,
  output logic [TRIM_W-1:0] lcd_trim
);

  cal_prescaler #(.DIV_LOG2(DIV_LOG2)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .stream_en (stream_en)
  );

  cal_second_counter #(
    .SEC_LOG2 (SEC_LOG2),
    .TRIM_W   (TRIM_W),
    .CAL_INIT (CAL_INIT)
  ) u_sec (
    .clk       (clk),
    .rst_n     (rst_n),
    .stream_en (stream_en),
    .cal_n     (cal_trim),
    .tick_1hz  (tick_1hz)
  );

  cal_trim_prog #(
    .TRIM_W   (TRIM_W),
    .CAL_INIT (CAL_INIT),
    .LCD_INIT (LCD_INIT)
  ) u_prog (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_mode   (prog_mode),
    .vpp_hi      (vpp_hi),
    .trim_sel    (trim_sel),
    .data_pulse  (data_pulse),
    .store_pulse (store_pulse),
    .work_trim   (work_trim),
    .cal_trim    (cal_trim),
    .lcd_trim    (lcd_trim)
  );

endmodule

// File: rtl/osc_trim_calibrator_chk.sv
module osc_trim_calibrator_chk #(
  parameter int DIV_LOG2 = 4,
  parameter int TRIM_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_mode,
  input logic              vpp_hi,
  input logic              trim_sel,
  input logic              stream_en,
  input logic              tick_1hz,
  input logic [TRIM_W-1:0] work_trim,
  input logic [TRIM_W-1:0] cal_trim,
  input logic [TRIM_W-1:0] lcd_trim
);

  localparam logic [DIV_LOG2-1:0] GAP_MAX = {DIV_LOG2{1'b1}};

  // Independent cycle counter used to judge the enable spacing.
  logic [DIV_LOG2-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n)              gap_q <= '0;
    else if (gap_q == GAP_MAX) gap_q <= '0;
    else                     gap_q <= gap_q + 1'b1;
  end

  assert_stream_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stream_en |-> (gap_q == GAP_MAX));

  assert_tick_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |-> stream_en);

  assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |=> !tick_1hz);

  assert_work_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(work_trim) |-> (work_trim == '0 || work_trim == $past(work_trim) + 1'b1));

  assert_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_mode && vpp_hi) |=> ($stable(work_trim) && $stable(cal_trim) && $stable(lcd_trim)));

  assert_cal_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cal_trim) |-> ($past(trim_sel) == 1'b0));

  assert_lcd_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lcd_trim) |-> ($past(trim_sel) == 1'b1));

endmodule

bind osc_trim_calibrator osc_trim_calibrator_chk #(
  .DIV_LOG2 (DIV_LOG2),
  .TRIM_W   (TRIM_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .prog_mode (prog_mode),
  .vpp_hi    (vpp_hi),
  .trim_sel  (trim_sel),
  .stream_en (stream_en),
  .tick_1hz  (tick_1hz),
  .work_trim (work_trim),
  .cal_trim  (cal_trim),
  .lcd_trim  (lcd_trim)
);

// File: tb/osc_trim_calibrator_tb.sv
module osc_trim_calibrator_tb;

  localparam int DIV_LOG2 = 2;
  localparam int SEC_LOG2 = 6;
  localparam int TRIM_W   = 5;
  localparam int DIV      = 1 << DIV_LOG2;
  localparam int SEC      = 1 << SEC_LOG2;
  localparam int TRIM_MOD = 1 << TRIM_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_mode = 1'b0, vpp_hi = 1'b0, trim_sel = 1'b0;
  logic data_pulse = 1'b0, store_pulse = 1'b0;
  logic stream_en, tick_1hz;
  logic [TRIM_W-1:0] work_trim, cal_trim, lcd_trim;

  osc_trim_calibrator #(
    .DIV_LOG2 (DIV_LOG2),
    .SEC_LOG2 (SEC_LOG2),
    .TRIM_W   (TRIM_W)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_mode   (prog_mode),
    .vpp_hi      (vpp_hi),
    .trim_sel    (trim_sel),
    .data_pulse  (data_pulse),
    .store_pulse (store_pulse),
    .stream_en   (stream_en),
    .tick_1hz    (tick_1hz),
    .work_trim   (work_trim),
    .cal_trim    (cal_trim),
    .lcd_trim    (lcd_trim)
  );

  always #4 clk = ~clk;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;
  int  m_work   = 0;
  bit  m_armed  = 1'b1;
  int  m_cal    = 0;
  int  m_lcd    = 0;
  int  bad_stream = 0, bad_tick = 0;
  int  since_en = 0;
  bit  seen_en = 1'b0, prev_tick = 1'b0;

  function automatic int exp_period(int n);
    return (SEC + n) * DIV;
  endfunction

  function automatic int exp_step(int w, bit armed);
    if (armed) return 0;
    return (w + 1) % TRIM_MOD;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor for enable spacing and tick shape, sampled on falling edges.
  always @(negedge clk) begin
    if (rst_n) begin
      since_en++;
      if (stream_en) begin
        if (seen_en && since_en != DIV) bad_stream++;
        seen_en  = 1'b1;
        since_en = 0;
      end
      if (tick_1hz && !stream_en) bad_tick++;
      if (tick_1hz && prev_tick)  bad_tick++;
      prev_tick = tick_1hz;
    end
  end

  task automatic set_levels(bit pm, bit vp, bit ts);
    @(negedge clk);
    prog_mode = pm; vpp_hi = vp; trim_sel = ts;
    @(negedge clk);
    if (!(pm && vp)) m_armed = 1'b1;
  endtask

  task automatic do_pulse(bit d, bit s);
    @(negedge clk);
    data_pulse = d; store_pulse = s;
    repeat (2) @(negedge clk);
    data_pulse = 1'b0; store_pulse = 1'b0;
    repeat (2) @(negedge clk);
    if (prog_mode && vpp_hi) begin
      if (s) begin
        if (!trim_sel) m_cal = m_work;
        else           m_lcd = m_work;
      end
      if (d) begin
        m_work  = exp_step(m_work, m_armed);
        m_armed = 1'b0;
      end
    end
  endtask

  task automatic measure(output int cyc);
    @(negedge clk);
    while (!tick_1hz) @(negedge clk);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!tick_1hz);
  endtask

  task automatic cmp_model(string tag);
    check({tag, " R6 work"}, int'(work_trim), m_work);
    check({tag, " R8 cal"},  int'(cal_trim),  m_cal);
    check({tag, " R8 lcd"},  int'(lcd_trim),  m_lcd);
  endtask

  initial begin
    int per;
    int unsigned seed;
    int unsigned r;
    seed = 32'd20240611;
    r = $urandom(seed);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 work reset", int'(work_trim), 0);
    check("R1 cal reset",  int'(cal_trim),  0);
    check("R1 lcd reset",  int'(lcd_trim),  0);
    check("R1 tick low",   int'(tick_1hz),  0);

    measure(per);
    check("R3 period n=0", per, exp_period(0));

    // R9: pulses without both enables have no effect.
    set_levels(1'b0, 1'b1, 1'b0);
    do_pulse(1'b1, 1'b0);
    do_pulse(1'b0, 1'b1);
    set_levels(1'b1, 1'b0, 1'b0);
    do_pulse(1'b1, 1'b1);
    check("R9 work locked", int'(work_trim), 0);
    check("R9 cal locked",  int'(cal_trim),  0);

    set_levels(1'b1, 1'b1, 1'b0);
    do_pulse(1'b1, 1'b0);
    check("R5 first clears", int'(work_trim), 0);
    repeat (5) do_pulse(1'b1, 1'b0);
    check("R6 five steps", int'(work_trim), 5);
    do_pulse(1'b0, 1'b1);
    check("R8 cal stored", int'(cal_trim), 5);
    check("R8 lcd untouched", int'(lcd_trim), 0);
    measure(per);
    measure(per);
    check("R3 period n=5", per, exp_period(5));

    // R10: leave and re-enter, next pulse clears again.
    set_levels(1'b0, 1'b1, 1'b0);
    set_levels(1'b1, 1'b1, 1'b0);
    do_pulse(1'b1, 1'b0);
    check("R10 rearm clears", int'(work_trim), 0);
    repeat (31) do_pulse(1'b1, 1'b0);
    check("R6 reach max", int'(work_trim), 31);
    do_pulse(1'b1, 1'b0);
    check("R7 wrap to zero", int'(work_trim), 0);

    repeat (3) do_pulse(1'b1, 1'b0);
    set_levels(1'b1, 1'b1, 1'b1);
    do_pulse(1'b1, 1'b1);
    check("R11 lcd pre-edge value", int'(lcd_trim), 3);
    check("R11 work still steps",   int'(work_trim), 4);
    check("R8 cal untouched",       int'(cal_trim), 5);

    repeat (27) do_pulse(1'b1, 1'b0);
    set_levels(1'b1, 1'b1, 1'b0);
    do_pulse(1'b0, 1'b1);
    check("R8 cal max", int'(cal_trim), 31);
    measure(per);
    measure(per);
    check("R3 period n=31", per, exp_period(31));

    // Constrained random mix.
    for (int i = 0; i < 80; i++) begin
      r = $urandom % 10;
      case (r)
        0, 1, 2, 3: do_pulse(1'b1, 1'b0);
        4:          do_pulse(1'b0, 1'b1);
        5:          do_pulse(1'b1, 1'b1);
        6:          set_levels(!prog_mode, vpp_hi, trim_sel);
        7:          set_levels(prog_mode, !vpp_hi, trim_sel);
        default:    set_levels(prog_mode, vpp_hi, !trim_sel);
      endcase
      cmp_model("rand");
    end

    measure(per);
    measure(per);
    check("R3 period random n", per, exp_period(m_cal));
    check("R2 enable spacing errors", bad_stream, 0);
    check("R4 tick shape errors", bad_tick, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R3 actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule